// File: doc/BRIEF.md
# Keyboard Scan Code Event Tracker

This block sits behind a PS/2 byte receiver and turns its stream of scan code bytes into key events. The receiver supplies a byte, a ready level that rises once per completed byte, and an error flag for a bad frame. The tracker takes a byte only on a low-to-high transition of ready. It keeps a shift history of the last three good bytes for display. It also decodes the stream into press and release events.

A byte other than the release prefix 0xF0 produces a press event carrying that byte. This covers every typematic repeat of a held key and prefix bytes such as 0xE0, which pass through unchanged. A 0xF0 byte arms a pending-release flag and produces no event. The next good byte then produces a release event for that key. The oldest history byte is kept only for display and never feeds the decision. A byte that arrives with the error flag set is discarded and cancels any pending release.

Top module: `scan_evt_tracker`

## Requirements
- R1: After reset, `evt_valid_o` is 0, `evt_release_o` is 0, `evt_code_o` is 0x00 and `hist_o` is all zeros.
- R2: A byte is accepted only in a cycle where `ready_i` is 1 and was 0 in the previous cycle. While `ready_i` stays high, no further byte is accepted, whatever `byte_i` does.
- R3: One cycle after a good byte is accepted, `hist_o` equals the previous `hist_o` shifted left by 8 bits, with the new byte in bits [7:0]. The byte two positions back sits in bits [23:16].
- R4: One cycle after a good byte other than 0xF0 is accepted with no release pending, `evt_valid_o` is 1, `evt_release_o` is 0 (press) and `evt_code_o` equals the byte.
- R5: A good 0xF0 byte produces no event (`evt_valid_o` stays 0) and makes the next good byte a release.
- R6: One cycle after the good byte that follows 0xF0 is accepted, `evt_valid_o` is 1, `evt_release_o` is 1 and `evt_code_o` equals that byte. The pending flag then clears, so the byte after that is a press again.
- R7: Repeating the same make code produces one press event per accepted byte.
- R8: A byte accepted while `err_i` is 1 changes nothing in `hist_o`, produces no event and cancels a pending release.
- R9: `evt_valid_o` is never high for two consecutive cycles.
- R10: An extended prefix byte 0xE0 is reported as a press with code 0xE0. A release code is taken from the byte after 0xF0, never from `hist_o[23:16]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_i | input | 8 | Received scan code byte |
| ready_i | input | 1 | Receiver byte-complete level; its rising edge accepts `byte_i` |
| err_i | input | 1 | Receiver frame error for the current byte |
| evt_valid_o | output | 1 | One-cycle key event strobe |
| evt_release_o | output | 1 | Event kind: 0 press, 1 release |
| evt_code_o | output | 8 | Key code of the last event |
| hist_o | output | 24 | Last three good bytes, newest in [7:0] |

## Verification
Every result is due exactly one clock edge after the edge that sees the rising ready level. The event strobe, the kind, the code and the history all register on that same edge. The event strobe must be low again on the edge after that. The bench drives inputs on the falling edge and samples 1 ns after the accepting rising edge. It then drops ready and samples one edge later to confirm the strobe has fallen. The bench sweeps all 256 byte values through press, repeat, prefix and release sequences, and keeps its own model of the history and the pending flag.

// File: rtl/scan_evt_pkg.sv
package scan_evt_pkg;
  localparam int unsigned SCAN_W = 8;
  typedef logic [SCAN_W-1:0] scan_t;

  typedef enum logic {
    EVT_PRESS   = 1'b0,
    EVT_RELEASE = 1'b1
  } evt_kind_e;

  typedef struct packed {
    evt_kind_e kind;
    scan_t     code;
  } evt_t;
endpackage

// File: rtl/scan_rdy_edge.sv
module scan_rdy_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ready_i,
  output logic accept_o
);
  logic ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ready_q <= 1'b0;
    else         ready_q <= ready_i;
  end

  assign accept_o = ready_i & ~ready_q;
endmodule

// File: rtl/scan_hist_shift.sv
module scan_hist_shift
  import scan_evt_pkg::*;
#(
  parameter int unsigned DEPTH  = 3,
  localparam int unsigned HIST_W = DEPTH * SCAN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  scan_t             byte_i,
  output logic [HIST_W-1:0] hist_o
);
  scan_t slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      slot_q[g] <= '0;
      else if (shift_i) slot_q[g] <= (g == 0) ? byte_i : slot_q[(g == 0) ? 0 : g-1];
    end
    assign hist_o[g*SCAN_W +: SCAN_W] = slot_q[g];
  end
endmodule

// File: rtl/scan_evt_decode.sv
module scan_evt_decode
  import scan_evt_pkg::*;
#(
  parameter scan_t BREAK_CODE = 8'hF0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  accept_i,
  input  logic  err_i,
  input  scan_t byte_i,
  output logic  valid_o,
  output evt_t  evt_o
);
  logic pend_q;
  logic is_break;

  assign is_break = (byte_i == BREAK_CODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      valid_o <= 1'b0;
      evt_o   <= '{kind: EVT_PRESS, code: '0};
    end else begin
      valid_o <= 1'b0;
      if (accept_i) begin
        if (err_i) begin
          pend_q <= 1'b0;
        end else if (is_break) begin
          pend_q <= 1'b1;
        end else begin
          valid_o    <= 1'b1;
          evt_o.kind <= pend_q ? EVT_RELEASE : EVT_PRESS;
          evt_o.code <= byte_i;
          pend_q     <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/scan_evt_tracker.sv
module scan_evt_tracker
  import scan_evt_pkg::*;
#(
  parameter int unsigned HIST_BYTES = 3,
  parameter scan_t       BREAK_CODE = 8'hF0,
  localparam int unsigned HIST_W    = HIST_BYTES * SCAN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SCAN_W-1:0] byte_i,
  input  logic              ready_i,
  input  logic              err_i,
  output logic              evt_valid_o,
  output logic              evt_release_o,
  output logic [SCAN_W-1:0] evt_code_o,
  output logic [HIST_W-1:0] hist_o
);
  logic accept;
  evt_t evt;

  scan_rdy_edge i_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ready_i  (ready_i),
    .accept_o (accept)
  );

  scan_hist_shift #(.DEPTH(HIST_BYTES)) i_hist (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (accept & ~err_i),
    .byte_i  (byte_i),
    .hist_o  (hist_o)
  );

  scan_evt_decode #(.BREAK_CODE(BREAK_CODE)) i_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .err_i    (err_i),
    .byte_i   (byte_i),
    .valid_o  (evt_valid_o),
    .evt_o    (evt)
  );

  assign evt_release_o = (evt.kind == EVT_RELEASE);
  assign evt_code_o    = evt.code;
endmodule

// File: rtl/scan_evt_tracker_chk.sv
module scan_evt_tracker_chk #(
  parameter int unsigned HIST_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [7:0]        byte_i,
  input logic              ready_i,
  input logic              err_i,
  input logic              evt_valid_o,
  input logic              evt_release_o,
  input logic [7:0]        evt_code_o,
  input logic [HIST_W-1:0] hist_o
);
  logic rdy_prev_q;
  logic acc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdy_prev_q <= 1'b0;
    else         rdy_prev_q <= ready_i;
  end
  assign acc = ready_i && !rdy_prev_q;

  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |=> !evt_valid_o);

  a_r2_event_needs_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> !evt_valid_o);

  a_r2_hist_needs_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> $stable(hist_o));

  a_r3_hist_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !err_i) |=> (hist_o == {$past(hist_o[HIST_W-9:0]), $past(byte_i)}));

  a_r4_press_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !err_i && byte_i != 8'hF0) |=> (evt_valid_o && evt_code_o == $past(byte_i)));

  a_r5_prefix_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !err_i && byte_i == 8'hF0) |=> !evt_valid_o);

  a_r8_err_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && err_i) |=> (!evt_valid_o && $stable(hist_o)));
endmodule

bind scan_evt_tracker scan_evt_tracker_chk #(.HIST_W(HIST_W)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .byte_i        (byte_i),
  .ready_i       (ready_i),
  .err_i         (err_i),
  .evt_valid_o   (evt_valid_o),
  .evt_release_o (evt_release_o),
  .evt_code_o    (evt_code_o),
  .hist_o        (hist_o)
);

// File: tb/test_scan_evt_tracker.sv
`timescale 1ns/1ps
module test_scan_evt_tracker;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  byte_i = 8'h00;
  logic        ready_i = 1'b0;
  logic        err_i = 1'b0;
  logic        evt_valid_o;
  logic        evt_release_o;
  logic [7:0]  evt_code_o;
  logic [23:0] hist_o;

  int checks = 0;
  int errors = 0;
  logic [23:0] exp_hist = '0;
  logic        exp_pend = 1'b0;
  logic        done = 1'b0;

  always #10 clk_i = ~clk_i;

  scan_evt_tracker i_scan_evt_tracker (
    .clk_i, .rst_ni, .byte_i, .ready_i, .err_i,
    .evt_valid_o, .evt_release_o, .evt_code_o, .hist_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one accepted byte, then ready drops; tag names the event requirement
  task automatic send(input logic [7:0] b, input logic e, input string tag);
    logic exp_v;
    logic exp_r;
    exp_v = 1'b0;
    exp_r = 1'b0;
    @(negedge clk_i);
    byte_i = b; err_i = e; ready_i = 1'b1;
    if (e) exp_pend = 1'b0;
    else begin
      exp_hist = {exp_hist[15:0], b};
      if (b == 8'hF0) exp_pend = 1'b1;
      else begin exp_v = 1'b1; exp_r = exp_pend; exp_pend = 1'b0; end
    end
    @(posedge clk_i); #1;
    check(tag, {31'd0, evt_valid_o}, {31'd0, exp_v});
    check(e ? "R8" : "R3", {8'd0, hist_o}, {8'd0, exp_hist});
    if (exp_v) begin
      check(tag, {31'd0, evt_release_o}, {31'd0, exp_r});
      check(tag, {24'd0, evt_code_o}, {24'd0, b});
    end
    @(negedge clk_i);
    ready_i = 1'b0; err_i = 1'b0;
    @(posedge clk_i); #1;
    check("R9", {31'd0, evt_valid_o}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    check("R1", {31'd0, evt_valid_o}, 32'd0);
    check("R1", {31'd0, evt_release_o}, 32'd0);
    check("R1", {24'd0, evt_code_o}, 32'd0);
    check("R1", {8'd0, hist_o}, 32'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check("R1", {31'd0, evt_valid_o}, 32'd0);

    // sweep every code: press, repeat, prefix, release
    for (int c = 0; c < 256; c++) begin
      if (c == 8'hF0) continue;
      send(8'(c), 1'b0, (c == 8'hE0) ? "R10" : "R4");
      send(8'(c), 1'b0, "R7");
      send(8'hF0, 1'b0, "R5");
      send(8'(c), 1'b0, "R6");
    end

    // R10: release code comes from the byte after the prefix, not history top
    send(8'h1C, 1'b0, "R4");
    send(8'hF0, 1'b0, "R5");
    send(8'h32, 1'b0, "R10");
    check("R10", {8'd0, hist_o}, {8'd0, 24'h1CF032});
    // R6: byte after a release is a press again
    send(8'h32, 1'b0, "R6");

    // R8: error byte dropped and cancels pending prefix
    for (int c = 0; c < 256; c += 17) begin
      send(8'hF0, 1'b0, "R5");
      send(8'(c), 1'b1, "R8");
      send(8'h2B, 1'b0, "R8");
    end

    // R2: ready held high, byte changes, nothing more accepted
    @(negedge clk_i);
    byte_i = 8'h4D; ready_i = 1'b1;
    exp_hist = {exp_hist[15:0], 8'h4D};
    @(posedge clk_i); #1;
    check("R2", {31'd0, evt_valid_o}, 32'd1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      byte_i = 8'h60 + 8'(k);
      @(posedge clk_i); #1;
      check("R2", {31'd0, evt_valid_o}, 32'd0);
      check("R2", {8'd0, hist_o}, {8'd0, exp_hist});
    end
    @(negedge clk_i); ready_i = 1'b0;
    @(posedge clk_i); #1;
    check("R2", {8'd0, hist_o}, {8'd0, exp_hist});
    send(8'h15, 1'b0, "R4");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule